// File: doc/BRIEF.md
# Two-Half Masked Interrupt Cause Controller

This block gathers up to sixty-four level-sensitive interrupt sources into one cause register. It also holds a CPU enable mask of the same width and drives a single interrupt line toward the processor. Software sees the block as a small register file on a plain read/write bus with a half-word data path. The cause and the mask are each split into a low half and a high half, and each half sits at its own address.

A fifth address returns a summary word. Software reads it first, so that one access tells which half holds the enabled pending causes. The summary returns the half that matters and sets a marker bit in that word to say so. Some cause positions are reserved and never latch a source. Positions 56 to 59 carry the four general-purpose-pin group requests, one per group of eight pins.

Top module: `irq_cause_ctrl`

## Requirements
- R1: On every clock edge out of reset, each non-reserved cause bit takes the level of its source input, and the read data reflects it from the following cycle.
- R2: Cause bits 29, 30, 31, 35, 51 to 55 and 61 to 63 always read as 0, whatever their source inputs do.
- R3: Address 0 reads cause bits 31:0 and address 1 reads cause bits 63:32, with bit 0 of the read word holding the lowest bit of that half.
- R4: A write to address 2 replaces mask bits 31:0 with the write data and leaves mask bits 63:32 unchanged. Address 2 reads back mask bits 31:0.
- R5: A write to address 3 replaces mask bits 63:32 with the write data and leaves mask bits 31:0 unchanged. Address 3 reads back mask bits 63:32.
- R6: Writes to addresses 0, 1 and 4 change neither the cause nor the mask.
- R7: Reading address 4 when no enabled cause is pending in bits 63:32 returns cause bits 31:0 unchanged.
- R8: Reading address 4 when enabled causes are pending only in bits 63:32 returns cause bits 63:32 with bit 30 set to 1.
- R9: Reading address 4 when enabled causes are pending in both halves returns cause bits 31:0 with bit 31 set to 1.
- R10: The interrupt output is a register that always equals the OR over all 64 bits of cause AND mask, as both stand in that cycle.
- R11: While reset is asserted the cause and the mask are zero and the interrupt output is low.
- R12: Addresses 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level interrupt sources, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Registered CPU interrupt request |

## Verification
The bench builds the block with its default half width of 32 and the default reserved-bit pattern. That is the only setting under which the two summary marker bits land at 30 and 31 and the reserved positions match the requirements. With a full 64-bit cause, the bench can reach each summary case, including the one where both halves are pending. It also drives every reserved position high to show that none of them latches. A long random run then mixes source changes with half-mask writes. This shows that a write to one mask half never disturbs the other half, and that the interrupt line tracks the masked cause cycle for cycle.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    typedef enum logic [2:0] {
        ADR_CAUSE_LO = 3'd0,
        ADR_CAUSE_HI = 3'd1,
        ADR_MASK_LO  = 3'd2,
        ADR_MASK_HI  = 3'd3,
        ADR_SUMMARY  = 3'd4
    } reg_addr_e;

    localparam int ADDR_W = 3;

endpackage

// File: rtl/irq_cause_latch.sv
module irq_cause_latch #(
    parameter int               HALF_W = 32,
    parameter logic [2*HALF_W-1:0] RSV = 64'hE0F8_0008_E000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] src_i,
    output logic [2*HALF_W-1:0] cause_o
);
    localparam int CW = 2 * HALF_W;

    typedef struct packed {
        logic [CW-1:0] cause;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cause = src_i & ~RSV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_cause_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] mask_o
);
    localparam int NHALF = 2;

    typedef struct packed {
        logic [NHALF-1:0][HALF_W-1:0] half;
    } msk_st_t;

    msk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NHALF; h++) begin
            if (wr_en && (addr == ADR_MASK_LO + ADDR_W'(h)))
                st_d.half[h] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.half;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_cause_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*HALF_W-1:0] cause,
    input  logic [2*HALF_W-1:0] mask,
    output logic [HALF_W-1:0]   rdata
);
    localparam int MARK_BOTH = HALF_W - 1;
    localparam int MARK_HIGH = HALF_W - 2;

    logic [2*HALF_W-1:0] pend;
    logic                lo_any, hi_any;
    logic [HALF_W-1:0]   summary;

    always_comb begin
        pend    = cause & mask;
        lo_any  = |pend[HALF_W-1:0];
        hi_any  = |pend[2*HALF_W-1:HALF_W];
        summary = cause[HALF_W-1:0];
        if (hi_any && !lo_any) begin
            summary            = cause[2*HALF_W-1:HALF_W];
            summary[MARK_HIGH] = 1'b1;
        end else if (hi_any) begin
            summary[MARK_BOTH] = 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CAUSE_LO: rdata = cause[HALF_W-1:0];
            ADR_CAUSE_HI: rdata = cause[2*HALF_W-1:HALF_W];
            ADR_MASK_LO:  rdata = mask[HALF_W-1:0];
            ADR_MASK_HI:  rdata = mask[2*HALF_W-1:HALF_W];
            ADR_SUMMARY:  rdata = summary;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cause_pkg::*;
#(
    parameter int                  HALF_W = 32,
    parameter logic [2*HALF_W-1:0] RSV    = 64'hE0F8_0008_E000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] src_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HALF_W-1:0]   wdata,
    output logic [HALF_W-1:0]   rdata,
    output logic                irq_o
);
    localparam int CW = 2 * HALF_W;

    logic [CW-1:0] cause_w, mask_w;
    logic [CW-1:0] cause_nx, mask_nx;

    irq_cause_latch #(.HALF_W(HALF_W), .RSV(RSV)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .cause_o(cause_w)
    );

    irq_mask_regs #(.HALF_W(HALF_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .mask_o(mask_w)
    );

    irq_read_mux #(.HALF_W(HALF_W)) u_rd (
        .addr(addr), .cause(cause_w), .mask(mask_w), .rdata(rdata)
    );

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t st_d, st_q;

    // Next-state view of cause and mask so the registered line lines up
    // with the registered cause and mask in the same cycle.
    always_comb begin
        cause_nx = src_i & ~RSV;
        mask_nx  = mask_w;
        if (wr_en && addr == ADR_MASK_LO) mask_nx[HALF_W-1:0]  = wdata;
        if (wr_en && addr == ADR_MASK_HI) mask_nx[CW-1:HALF_W] = wdata;
        st_d     = st_q;
        st_d.irq = |(cause_nx & mask_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_cause_pkg::*;
#(
    parameter int                  HALF_W = 32,
    parameter logic [2*HALF_W-1:0] RSV    = 64'hE0F8_0008_E000_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*HALF_W-1:0] src_i,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [HALF_W-1:0]   wdata,
    input logic [HALF_W-1:0]   rdata,
    input logic                irq_o,
    input logic [2*HALF_W-1:0] cause_q,
    input logic [2*HALF_W-1:0] mask_q
);
    localparam int CW = 2 * HALF_W;

    logic [CW-1:0] pend;
    assign pend = cause_q & mask_q;

    p_cause_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cause_q == ($past(src_i) & ~RSV));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & RSV) == '0);

    p_mask_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_MASK_LO) |=>
            (mask_q[HALF_W-1:0] == $past(wdata)) &&
            (mask_q[CW-1:HALF_W] == $past(mask_q[CW-1:HALF_W])));

    p_mask_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_MASK_HI) |=>
            (mask_q[CW-1:HALF_W] == $past(wdata)) &&
            (mask_q[HALF_W-1:0] == $past(mask_q[HALF_W-1:0])));

    p_summary_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_SUMMARY && pend[HALF_W-1:0] == '0 && pend[CW-1:HALF_W] != '0)
            |-> rdata[HALF_W-2] && rdata[HALF_W-3:0] == cause_q[CW-3:HALF_W]);

    p_irq_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|pend));
endmodule

bind irq_cause_ctrl irq_cause_chk #(.HALF_W(HALF_W), .RSV(RSV)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .cause_q(cause_w), .mask_q(mask_w)
);

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
    localparam logic [63:0] RSV_M = 64'hE0F8_0008_E000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    logic [63:0] cm = '0;
    logic [63:0] mm = '0;
    logic        im = 1'b0;

    always #5 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        logic [63:0] p;
        p = cm & mm;
        case (a)
            3'd0: return cm[31:0];
            3'd1: return cm[63:32];
            3'd2: return mm[31:0];
            3'd3: return mm[63:32];
            3'd4: begin
                if (p[63:32] != 0 && p[31:0] == 0) return cm[63:32] | 32'h4000_0000;
                if (p[63:32] != 0) return cm[31:0] | 32'h8000_0000;
                return cm[31:0];
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] a);
        logic [63:0] p;
        p = cm & mm;
        case (a)
            3'd0, 3'd1: return "R1";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: begin
                if (p[63:32] != 0 && p[31:0] == 0) return "R8";
                if (p[63:32] != 0) return "R9";
                return "R7";
            end
            default: return "R12";
        endcase
    endfunction

    task automatic chk32(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", t, act, exp);
        end
    endtask

    task automatic chk1(input string t, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
        end
    endtask

    // One clock: drive inputs, check read and irq on current state, then advance model.
    task automatic step(input logic [63:0] s, input logic we, input logic [2:0] a,
                        input logic [31:0] wd, input string t);
        @(negedge clk);
        src_i = s; wr_en = we; addr = a; wdata = wd;
        #1;
        chk32(t, rdata, model_rd(a));
        chk1("R10", irq_o, im);
        @(posedge clk);
        cm = s & ~RSV_M;
        if (we && a == 3'd2) mm[31:0]  = wd;
        if (we && a == 3'd3) mm[63:32] = wd;
        im = |(cm & mm);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset holds state cleared even with sources active
        src_i = '1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            addr = 3'(k);
            #1;
            chk32("R11", rdata, 32'h0);
            chk1("R11", irq_o, 1'b0);
        end
        @(negedge clk);
        addr = 3'd3; #1;
        chk32("R11", rdata, 32'h0);
        src_i = '0;
        rst_n = 1'b1;

        // R1 / R3: cause halves follow sources
        step(64'h1234_5678_0ABC_DEF1, 1'b0, 3'd0, 0, "R3");
        step(64'h0000_0000_0000_0000, 1'b0, 3'd0, 0, "R3");
        step(64'h0000_0000_0000_0000, 1'b0, 3'd1, 0, "R1");
        step(64'h0F00_0000_0000_0001, 1'b0, 3'd1, 0, "R1");
        // R2: all sources high, reserved bits must stay 0
        step('1, 1'b0, 3'd0, 0, "R3");
        step('1, 1'b0, 3'd0, 0, "R2");
        step('1, 1'b0, 3'd1, 0, "R2");
        chk32("R2", rdata, ~RSV_M[63:32]);
        // R4 / R5: half writes
        step('0, 1'b1, 3'd2, 32'h0000_FFFF, "R4");
        step('0, 1'b1, 3'd3, 32'hA5A5_0001, "R5");
        step('0, 1'b0, 3'd2, 0, "R4");
        step('0, 1'b1, 3'd2, 32'h0000_0100, "R4");
        step('0, 1'b0, 3'd3, 0, "R5");
        chk32("R5", rdata, 32'hA5A5_0001);
        step('0, 1'b0, 3'd2, 0, "R4");
        chk32("R4", rdata, 32'h0000_0100);
        // R7: only low pending
        step(64'h0000_0000_0000_0100, 1'b0, 3'd4, 0, "R7");
        step(64'h0000_0000_0000_0100, 1'b0, 3'd4, 0, "R7");
        chk32("R7", rdata, 32'h0000_0100);
        // R8: only high pending (mask hi bit 0 -> cause bit 32)
        step(64'h0000_0001_0000_0002, 1'b0, 3'd4, 0, "R7");
        step(64'h0000_0001_0000_0002, 1'b0, 3'd4, 0, "R8");
        chk32("R8", rdata, 32'h4000_0001);
        // R9: both halves pending
        step(64'h0000_0001_0000_0102, 1'b0, 3'd4, 0, "R8");
        step(64'h0000_0001_0000_0102, 1'b0, 3'd4, 0, "R9");
        chk32("R9", rdata, 32'h8000_0102);
        // R7: nothing enabled pending
        step(64'h0000_0002_0000_0001, 1'b0, 3'd4, 0, "R9");
        step(64'h0000_0002_0000_0001, 1'b0, 3'd4, 0, "R7");
        chk32("R7", rdata, 32'h0000_0001);
        // R6: writes to cause and summary addresses are ignored
        step(64'h0000_0002_0000_0001, 1'b1, 3'd0, 32'hFFFF_FFFF, "R6");
        step(64'h0000_0002_0000_0001, 1'b1, 3'd1, 32'hFFFF_FFFF, "R6");
        step(64'h0000_0002_0000_0001, 1'b1, 3'd4, 32'hFFFF_FFFF, "R6");
        step(64'h0000_0002_0000_0001, 1'b0, 3'd2, 0, "R6");
        chk32("R6", rdata, 32'h0000_0100);
        step(64'h0000_0002_0000_0001, 1'b0, 3'd3, 0, "R6");
        chk32("R6", rdata, 32'hA5A5_0001);
        step(64'h0000_0002_0000_0001, 1'b0, 3'd0, 0, "R6");
        chk32("R6", rdata, 32'h0000_0001);
        // R12: unmapped addresses read 0
        for (int a = 5; a < 8; a++) begin
            step('1, 1'b0, 3'(a), 0, "R12");
            chk32("R12", rdata, 32'h0);
        end
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [63:0] s;
            logic [2:0]  a;
            logic        we;
            logic [31:0] wd;
            s  = {$urandom, $urandom} & {$urandom, $urandom};
            a  = 3'($urandom_range(0, 7));
            we = ($urandom_range(0, 3) == 0);
            wd = $urandom & $urandom;
            step(s, we, a, wd, tag_for(a));
        end
        @(negedge clk);
        chk1("R10", irq_o, im);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule